// File: doc/BRIEF.md
# Shared-Pin Local Reset and NMI Router

This block takes one active-low local-reset pin and one active-low non-maskable interrupt pin that serve a group of eight processor cores. It steers them to a single core or to all cores together. A core-select code and an active-low enable pin decide what the pins mean. All four pin groups arrive without a clock relation, so each one passes through a synchroniser. The block then checks that the sampled values are stable. Only after that does it decode them into one of three commands: assert reset, assert NMI, or release both.

Each core has a held local-reset bit and a held NMI bit. The reset bit drives a level output to that core. The NMI bit produces a one-cycle pulse when it rises. A board controller or debug agent uses the block to hold a chosen core in reset, to interrupt it, or to let it run, while the other cores keep their state.

Top module: `lrn_router`

## Requirements
- R1: While the enable pin `route_en_n_i` is high, no command is applied, whatever the other pins are. No reset output rises and no NMI pulse is produced.
- R2: With the enable pin low, select codes 0 through 7 (top bit 0, low three bits = core index) address exactly that one core.
- R3: Any select code whose top bit (bit 3) is 1 addresses all eight cores at once, whatever the low bits are.
- R4: With the enable pin low and the reset pin low, the held reset bit of each addressed core is set, so `core_rst_o[c]` goes to 1. The NMI pin is ignored in this case and no NMI pulse is produced.
- R5: With the enable pin low and both the reset and NMI pins high, the held reset and NMI bits of each addressed core are cleared, so `core_rst_o[c]` goes to 0.
- R6: With the enable pin low, the reset pin high and the NMI pin low, the held NMI bit of each addressed core is set. The core's reset bit is left as it was.
- R7: An assert-reset command also clears the held NMI bit of the addressed core. A later assert-NMI command to that core therefore gives a new pulse.
- R8: `core_nmi_o[c]` is a pulse exactly one clock wide, given once when core c's held NMI bit rises. A repeated or continuously held NMI command gives no further pulse.
- R9: Cores that are not addressed keep their reset and NMI state unchanged.
- R10: A command acts only after the synchronised select and pin values have been equal on two consecutive clock samples. A pin or select change that lasts one clock has no effect. A stable command shows at the outputs within 6 clock cycles.
- R11: A low level on the synchronous system reset `rst_n` clears every held reset and NMI bit. Both output vectors read 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| core_sel_i | input | 4 | Asynchronous core-select code; bit 3 selects broadcast |
| lrst_pin_n_i | input | 1 | Asynchronous shared local-reset pin, active low |
| nmi_pin_n_i | input | 1 | Asynchronous shared NMI pin, active low |
| route_en_n_i | input | 1 | Asynchronous enable pin, active low |
| core_rst_o | output | 8 | Per-core local-reset level, 1 = held in reset |
| core_nmi_o | output | 8 | Per-core NMI pulse, one cycle wide |

## Verification
The bench builds the router with its default parameters: eight cores, a four-bit select code and a two-stage synchroniser. With these values every single-core code and several broadcast codes can be driven in turn, and a one-cycle glitch on a pin or on the select code can be tested against the stability filter. The bench counts NMI pulses per core over each command window. This shows whether a held NMI command fires once, whether an assert-reset re-arms the NMI bit, and whether cores that were not addressed stay quiet.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

    // Command decoded from the qualified pin combination
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RST  = 2'd1,
        CMD_NMI  = 2'd2,
        CMD_REL  = 2'd3
    } lrn_cmd_e;

endpackage

// File: rtl/lrn_sync.sv
module lrn_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/lrn_decode.sv
module lrn_decode
    import lrn_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel_s,
    input  logic                 en_n_s,
    input  logic                 lrst_n_s,
    input  logic                 nmi_n_s,
    output lrn_cmd_e             cmd_o,
    output logic [NUM_CORES-1:0] mask_o
);

    localparam int IDX_W = SEL_W - 1;
    localparam int SMP_W = SEL_W + 3;
    localparam logic [SMP_W-1:0] IDLE_SMP = {{SEL_W{1'b0}}, 3'b111};

    typedef struct packed {
        logic [SMP_W-1:0]     prev;
        lrn_cmd_e             cmd;
        logic [NUM_CORES-1:0] mask;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [SMP_W-1:0] smp;
    logic             stable;

    assign smp    = {sel_s, en_n_s, lrst_n_s, nmi_n_s};
    assign stable = (smp == st_q.prev);

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp;
        st_d.cmd  = CMD_NONE;
        st_d.mask = '0;
        if (stable && !en_n_s) begin
            if (!lrst_n_s) begin
                st_d.cmd = CMD_RST;
            end else if (nmi_n_s) begin
                st_d.cmd = CMD_REL;
            end else begin
                st_d.cmd = CMD_NMI;
            end
            if (sel_s[SEL_W-1]) begin
                st_d.mask = '1;
            end else begin
                for (int c = 0; c < NUM_CORES; c++) begin
                    st_d.mask[c] = (sel_s[IDX_W-1:0] == IDX_W'(c));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= IDLE_SMP;
            st_q.cmd  <= CMD_NONE;
            st_q.mask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = st_q.cmd;
    assign mask_o = st_q.mask;

    // Enable pin high: no command leaves the decoder
    assert_idle_no_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> (cmd_o == CMD_NONE));

    // Values that changed since the last sample never produce a command
    assert_unstable_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp != st_q.prev) |=> (cmd_o == CMD_NONE));

    // Broadcast code reaches every core
    assert_bcast_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && !en_n_s && sel_s[SEL_W-1]) |=> (mask_o == '1));

    // A single-core code addresses at most one core
    assert_single_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s[SEL_W-1]) |=> $onehot0(mask_o));

endmodule

// File: rtl/lrn_core_state.sv
module lrn_core_state
    import lrn_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lrn_cmd_e             cmd_i,
    input  logic [NUM_CORES-1:0] mask_i,
    output logic [NUM_CORES-1:0] rst_o,
    output logic [NUM_CORES-1:0] nmi_o
);

    typedef struct packed {
        logic [NUM_CORES-1:0] rst_held;
        logic [NUM_CORES-1:0] nmi_held;
        logic [NUM_CORES-1:0] nmi_pulse;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (mask_i[c]) begin
                unique case (cmd_i)
                    CMD_RST: begin
                        st_d.rst_held[c] = 1'b1;
                        st_d.nmi_held[c] = 1'b0;
                    end
                    CMD_NMI: begin
                        st_d.nmi_held[c] = 1'b1;
                    end
                    CMD_REL: begin
                        st_d.rst_held[c] = 1'b0;
                        st_d.nmi_held[c] = 1'b0;
                    end
                    default: ;
                endcase
            end
            st_d.nmi_pulse[c] = st_d.nmi_held[c] & ~st_q.nmi_held[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o = st_q.rst_held;
    assign nmi_o = st_q.nmi_pulse;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core_chk
        // Pulse lasts a single cycle
        assert_nmi_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            nmi_o[g] |=> !nmi_o[g]);

        // Unaddressed cores keep their reset level
        assert_unaddressed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_i[g] |=> $stable(rst_o[g]));

        // Assert-reset drops any pending NMI and holds reset
        assert_rst_clears_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i[g] && cmd_i == CMD_RST) |=> (rst_o[g] && !nmi_o[g]));

        // Assert-NMI leaves the reset level alone
        assert_nmi_keeps_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i[g] && cmd_i == CMD_NMI) |=> $stable(rst_o[g]));
    end

endmodule

// File: rtl/lrn_router.sv
module lrn_router
    import lrn_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = $clog2(NUM_CORES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     core_sel_i,
    input  logic                 lrst_pin_n_i,
    input  logic                 nmi_pin_n_i,
    input  logic                 route_en_n_i,
    output logic [NUM_CORES-1:0] core_rst_o,
    output logic [NUM_CORES-1:0] core_nmi_o
);

    localparam int PIN_W = SEL_W + 3;
    localparam logic [PIN_W-1:0] PIN_IDLE = {{SEL_W{1'b0}}, 3'b111};

    logic [PIN_W-1:0] pins_raw, pins_s;
    lrn_cmd_e             cmd;
    logic [NUM_CORES-1:0] mask;

    assign pins_raw = {core_sel_i, route_en_n_i, lrst_pin_n_i, nmi_pin_n_i};

    lrn_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    lrn_decode #(
        .NUM_CORES (NUM_CORES),
        .SEL_W     (SEL_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (pins_s[PIN_W-1:3]),
        .en_n_s   (pins_s[2]),
        .lrst_n_s (pins_s[1]),
        .nmi_n_s  (pins_s[0]),
        .cmd_o    (cmd),
        .mask_o   (mask)
    );

    lrn_core_state #(
        .NUM_CORES (NUM_CORES)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .mask_i (mask),
        .rst_o  (core_rst_o),
        .nmi_o  (core_nmi_o)
    );

    // A release command clears reset on every addressed core
    assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REL) |=> ((core_rst_o & mask) == '0) || !$stable(mask));

endmodule

// File: tb/sim_lrn_router.sv
`timescale 1ns/1ps
module sim_lrn_router;

    localparam int NC = 8;
    localparam int SETTLE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    sel = 4'd0;
    logic          lrst_n = 1'b1;
    logic          nmi_n = 1'b1;
    logic          en_n = 1'b1;
    logic [NC-1:0] rst_o, nmi_o;

    int total = 0;
    int bad = 0;
    int pulses [NC];
    int base [NC];
    logic [NC-1:0] exp_rst = '0;

    always #2 clk = ~clk;

    lrn_router u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_sel_i   (sel),
        .lrst_pin_n_i (lrst_n),
        .nmi_pin_n_i  (nmi_n),
        .route_en_n_i (en_n),
        .core_rst_o   (rst_o),
        .core_nmi_o   (nmi_o)
    );

    initial for (int c = 0; c < NC; c++) pulses[c] = 0;

    always @(posedge clk) begin
        for (int c = 0; c < NC; c++) if (nmi_o[c]) pulses[c] = pulses[c] + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic e, input logic r, input logic n);
        @(negedge clk);
        for (int c = 0; c < NC; c++) base[c] = pulses[c];
        sel = s; en_n = e; lrst_n = r; nmi_n = n;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic idle();
        drive(4'd0, 1'b1, 1'b1, 1'b1);
    endtask

    function automatic logic [NC-1:0] tgt(input logic [3:0] s);
        return s[3] ? '1 : NC'(1) << s[2:0];
    endfunction

    task automatic chk_pulses(input string req, input logic [NC-1:0] expm);
        for (int c = 0; c < NC; c++) chk(req, pulses[c] - base[c], int'(expm[c]));
    endtask

    task automatic t_reset_state();
        chk("R11 reset rst_o", int'(rst_o), 0);
        chk("R11 reset nmi_o", int'(nmi_o), 0);
    endtask

    task automatic t_disabled();
        drive(4'd0, 1'b1, 1'b0, 1'b0);
        chk("R1 disabled rst", int'(rst_o), 0);
        chk_pulses("R1 disabled nmi", '0);
        drive(4'd9, 1'b1, 1'b1, 1'b0);
        chk_pulses("R1 disabled nmi bcast", '0);
        idle();
    endtask

    task automatic t_per_core();
        for (int c = 0; c < NC; c++) begin
            drive(4'(c), 1'b0, 1'b0, c[0]);
            exp_rst |= tgt(4'(c));
            chk("R2 R4 R9 per-core assert", int'(rst_o), int'(exp_rst));
            chk_pulses("R4 nmi pin ignored", '0);
            idle();
            chk("R9 held after idle", int'(rst_o), int'(exp_rst));
        end
        for (int c = 0; c < NC; c++) begin
            drive(4'(c), 1'b0, 1'b1, 1'b1);
            exp_rst &= ~tgt(4'(c));
            chk("R5 R9 per-core release", int'(rst_o), int'(exp_rst));
            idle();
        end
    endtask

    task automatic t_nmi();
        for (int c = 0; c < NC; c++) begin
            drive(4'(c), 1'b0, 1'b1, 1'b0);
            chk_pulses("R6 R8 nmi single pulse", tgt(4'(c)));
            chk("R6 nmi leaves rst", int'(rst_o), int'(exp_rst));
            drive(4'(c), 1'b0, 1'b1, 1'b0);
            chk_pulses("R8 repeat nmi no pulse", '0);
            drive(4'(c), 1'b0, 1'b1, 1'b1);
            idle();
        end
        drive(4'd3, 1'b0, 1'b0, 1'b1);
        exp_rst = tgt(4'd3);
        idle();
        drive(4'd3, 1'b0, 1'b1, 1'b0);
        chk("R6 nmi keeps rst held", int'(rst_o), int'(exp_rst));
        chk_pulses("R6 nmi while in reset", tgt(4'd3));
        drive(4'd3, 1'b0, 1'b1, 1'b1);
        exp_rst = '0;
        chk("R5 release both", int'(rst_o), 0);
        idle();
    endtask

    task automatic t_rst_clears_nmi();
        drive(4'd2, 1'b0, 1'b1, 1'b0);
        chk_pulses("R7 first nmi", tgt(4'd2));
        drive(4'd2, 1'b0, 1'b0, 1'b1);
        chk("R7 reset asserted", int'(rst_o), int'(tgt(4'd2)));
        drive(4'd2, 1'b0, 1'b1, 1'b0);
        chk_pulses("R7 nmi re-armed by reset", tgt(4'd2));
        chk("R7 reset kept", int'(rst_o), int'(tgt(4'd2)));
        drive(4'd2, 1'b0, 1'b1, 1'b1);
        idle();
    endtask

    task automatic t_bcast();
        drive(4'b1010, 1'b0, 1'b0, 1'b1);
        chk("R3 bcast reset", int'(rst_o), 'hFF);
        idle();
        drive(4'b1111, 1'b0, 1'b1, 1'b0);
        chk_pulses("R3 bcast nmi", '1);
        drive(4'b1000, 1'b0, 1'b1, 1'b1);
        chk("R3 bcast release", int'(rst_o), 0);
        idle();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        en_n = 1'b0; lrst_n = 1'b0; sel = 4'd4;
        @(negedge clk);
        en_n = 1'b1; lrst_n = 1'b1; sel = 4'd0;
        repeat (SETTLE) @(negedge clk);
        chk("R10 one-cycle pin glitch", int'(rst_o), 0);
        drive(4'd1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        sel = 4'd6;
        @(negedge clk);
        sel = 4'd1;
        repeat (SETTLE) @(negedge clk);
        chk("R10 one-cycle select glitch", int'(rst_o), int'(tgt(4'd1)));
        drive(4'd1, 1'b0, 1'b1, 1'b1);
        idle();
        @(negedge clk);
        sel = 4'd5; en_n = 1'b0; lrst_n = 1'b0;
        repeat (6) @(posedge clk);
        #1 chk("R10 latency within 6 cycles", int'(rst_o), int'(tgt(4'd5)));
        drive(4'd5, 1'b0, 1'b1, 1'b1);
        idle();
    endtask

    task automatic t_sysreset();
        drive(4'd8, 1'b0, 1'b0, 1'b1);
        idle();
        drive(4'd7, 1'b0, 1'b1, 1'b0);
        idle();
        @(negedge clk);
        for (int c = 0; c < NC; c++) base[c] = pulses[c];
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 system reset clears rst", int'(rst_o), 0);
        rst_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk("R11 stays clear", int'(rst_o), 0);
        chk_pulses("R11 no nmi after reset", '0);
        drive(4'd7, 1'b0, 1'b1, 1'b0);
        chk_pulses("R11 nmi bit was cleared", tgt(4'd7));
        idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_disabled();
        t_per_core();
        t_nmi();
        t_rst_clears_nmi();
        t_bcast();
        t_glitch();
        t_sysreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule